// File: doc/BRIEF.md
# Parallel Flash Command Front End

This block models the command side of a parallel NOR-style flash device. A host drives chip-enable, write-enable and output-enable strobes plus an address and data bus. The block samples these strobes in its own clock domain and recognises unlock sequences of several writes. It then starts an internal program or sector-erase engine and narrows the set of commands it accepts while that engine is busy. The storage is a small behavioural array that starts erased (all ones).

While an operation runs, reads return a status word instead of array data. One bit gives a polling value and another bit flips on every read. A ready/busy output shows whether the engine is working. A sector erase can be paused so that other sectors can be read, and then resumed. An active-low hardware reset input aborts any operation and returns the decoder to read mode. A bus-width input selects word or byte access.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Writing AAh at word address 555h, then 55h at 2AAh, then A0h at 555h, then one more write starts a program of that write's address and data. `ry_by` is low for exactly PROG_CYC clock cycles after the clock edge that ends the last write.
- R2: If either unlock write carries the wrong address or data, the decoder returns to read mode. A following A0h write and data write then change nothing in the array.
- R3: Programming can only clear bits, so the stored word becomes the old word AND the written data.
- R4: A write's address is taken when the write begins (CE# and WE# both low). Its data is taken when the write ends (WE# or CE# released). Changes to the address bus in between have no effect.
- R5: While a program runs, every command write is ignored. The operation completes with the originally latched data.
- R6: Writing AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h to any address in a sector erases that sector. The sector has 2^(MEM_AW-SECT_W) words and is selected by the top SECT_W bits of the word address. All its words become FFFFh after ERASE_CYC busy cycles, and other sectors are unchanged.
- R7: During a sector erase, only B0h (at any address) is accepted. It suspends the erase: `ry_by` goes high, the erase progress is frozen and reads return array data. While suspended, only 30h resumes the erase.
- R8: While a program or erase runs, reads return a status word. Bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during an erase. Bit 6 is 1 on the first read of an operation and flips on every later read. All other bits are 0. Once the operation finishes, reads return array data.
- R9: Holding `hw_rst_n` low for one clock aborts any running operation without changing the array and returns the decoder to read mode with `ry_by` high.
- R10: With `byte_n` low, the bus is 8 bits wide and `dq_in[15]` acts as the byte address bit (1 = upper byte). A program writes only the selected byte. A read returns the selected byte on `dq_out[7:0]` with the upper bits at 0.
- R11: After `rst_n` the array reads FFFFh everywhere and `ry_by` is high. `dq_oe` is high exactly while chip-enable and output-enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low; erases the array |
| hw_rst_n | input | 1 | Device reset pin, active low; aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data; bit 15 is the byte address in 8-bit mode |
| dq_out | output | 16 | Read data or status word |
| dq_oe | output | 1 | Read drive enable |
| ry_by | output | 1 | 1 = ready, 0 = operation in progress |

## Verification
On every cycle, the assertions check the following:
- A running program holds its state through any command write.
- During an erase, only the suspend code leaves the erase state.
- The engine counter loads on start and stays frozen while suspended.
- The hardware reset lands the decoder in read mode.
- The status toggle bit flips on each busy read.

Only the bench scenarios can show the end-to-end results:
- the exact busy length;
- AND-only programming;
- the split between address and data capture;
- erase confined to one sector;
- byte-lane behaviour;
- that an aborted program leaves the array untouched.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PADDR,
    ST_E0, ST_E1, ST_E2,
    ST_PROG, ST_ERASE, ST_SUSP
  } fstate_t;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERS_SET = 8'h80;
  localparam logic [7:0] CMD_ERS_GO  = 8'h30;
  localparam logic [7:0] CMD_PAUSE   = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

endpackage

// File: rtl/flash_strobe.sv
module flash_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start,
  output logic wr_end,
  output logic rd_start,
  output logic rd_act
);
  logic wr_act, wr_q, rd_q;

  assign wr_act   = ~ce_n & ~we_n;
  assign rd_act   = ~ce_n & ~oe_n;
  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign rd_start = rd_act & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 6,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  input  logic              byte_n,
  input  logic              eng_done,
  output fstate_t           state,
  output logic [MEM_AW-1:0] tgt_addr,
  output logic [15:0]       tgt_data,
  output logic [SECT_W-1:0] tgt_sect,
  output logic              prog_b7,
  output logic              start_op,
  output logic              start_ers
);
  fstate_t           state_d;
  logic [ADDR_W-1:0] alat;
  logic              lane_lat;
  logic              ld_prog, ld_sect;
  logic [7:0]        cmd;
  logic              at_a, at_b;

  assign cmd  = dq_in[7:0];
  assign at_a = (alat == ADDR_W'(KEY_ADDR_A));
  assign at_b = (alat == ADDR_W'(KEY_ADDR_B));

  always_comb begin
    state_d   = state;
    start_op  = 1'b0;
    start_ers = 1'b0;
    ld_prog   = 1'b0;
    ld_sect   = 1'b0;
    if (!hw_rst_n || eng_done) begin
      state_d = ST_READ;
    end else if (wr_end) begin
      case (state)
        ST_READ:  if (cmd == CMD_KEY_A && at_a) state_d = ST_UNL1;
        ST_UNL1:  state_d = (cmd == CMD_KEY_B && at_b) ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (cmd == CMD_PROGRAM && at_a)      state_d = ST_PADDR;
          else if (cmd == CMD_ERS_SET && at_a) state_d = ST_E0;
          else                                 state_d = ST_READ;
        end
        ST_PADDR: begin
          state_d  = ST_PROG;
          start_op = 1'b1;
          ld_prog  = 1'b1;
        end
        ST_E0: state_d = (cmd == CMD_KEY_A && at_a) ? ST_E1 : ST_READ;
        ST_E1: state_d = (cmd == CMD_KEY_B && at_b) ? ST_E2 : ST_READ;
        ST_E2: begin
          if (cmd == CMD_ERS_GO) begin
            state_d   = ST_ERASE;
            start_op  = 1'b1;
            start_ers = 1'b1;
            ld_sect   = 1'b1;
          end else begin
            state_d = ST_READ;
          end
        end
        ST_ERASE: if (cmd == CMD_PAUSE)  state_d = ST_SUSP;
        ST_SUSP:  if (cmd == CMD_RESUME) state_d = ST_ERASE;
        default:  state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      alat     <= '0;
      lane_lat <= 1'b0;
      tgt_addr <= '0;
      tgt_data <= '1;
      tgt_sect <= '0;
      prog_b7  <= 1'b0;
    end else begin
      state <= state_d;
      if (wr_start) begin
        alat     <= addr;
        lane_lat <= dq_in[15];
      end
      if (ld_prog) begin
        tgt_addr <= alat[MEM_AW-1:0];
        prog_b7  <= byte_n ? dq_in[7] : cmd[7];
        if (byte_n)        tgt_data <= dq_in;
        else if (lane_lat) tgt_data <= {cmd, 8'hFF};
        else               tgt_data <= {8'hFF, cmd};
      end
      if (ld_sect) tgt_sect <= alat[MEM_AW-1 -: SECT_W];
    end
  end

  // R5
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && !eng_done && hw_rst_n) |=> (state == ST_PROG));

  // R7
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && wr_end && cmd == CMD_PAUSE && !eng_done && hw_rst_n)
      |=> (state == ST_SUSP));

  // R7
  ers_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && cmd != CMD_PAUSE && !eng_done && hw_rst_n)
      |=> (state == ST_ERASE));

  // R9
  hwrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> (state == ST_READ));
endmodule

// File: rtl/flash_engine.sv
module flash_engine #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  input  logic start_ers,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(ERASE_CYC + 1);

  logic [CW-1:0] cnt, cnt_d;

  assign done = run & ~abort & (cnt == CW'(1));

  always_comb begin
    cnt_d = cnt;
    if (abort)                 cnt_d = '0;
    else if (start)            cnt_d = start_ers ? CW'(ERASE_CYC) : CW'(PROG_CYC);
    else if (run && cnt != '0) cnt_d = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (cnt != '0));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start && !abort) |=> $stable(cnt));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int MEM_AW = 6,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              ers_en,
  input  logic [SECT_W-1:0] ers_sect,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int SH    = MEM_AW - SECT_W;

  logic [15:0] mem   [DEPTH];
  logic [15:0] mem_d [DEPTH];

  assign rd_data = mem[rd_addr];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem[i];
      if (ers_en && SECT_W'(MEM_AW'(i) >> SH) == ers_sect) mem_d[i] = '1;
    end
    if (wr_en) mem_d[wr_addr] = mem[wr_addr] & wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_d[i];
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_AW    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              byte_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              ry_by
);
  logic              wr_start, wr_end, rd_start, rd_act;
  fstate_t           state;
  logic [MEM_AW-1:0] tgt_addr;
  logic [15:0]       tgt_data, rd_word, rd_val, status;
  logic [SECT_W-1:0] tgt_sect;
  logic              prog_b7, start_op, start_ers, eng_done, busy;
  logic              tog, tog_d;

  flash_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_start(wr_start), .wr_end(wr_end), .rd_start(rd_start), .rd_act(rd_act)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SECT_W(SECT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
    .wr_start(wr_start), .wr_end(wr_end), .addr(addr), .dq_in(dq_in),
    .byte_n(byte_n), .eng_done(eng_done), .state(state),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_sect(tgt_sect),
    .prog_b7(prog_b7), .start_op(start_op), .start_ers(start_ers)
  );

  assign busy = (state == ST_PROG) || (state == ST_ERASE);

  flash_engine #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .abort(~hw_rst_n), .start(start_op),
    .start_ers(start_ers), .run(busy), .done(eng_done)
  );

  flash_array #(.MEM_AW(MEM_AW), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(eng_done && state == ST_PROG), .wr_addr(tgt_addr), .wr_data(tgt_data),
    .ers_en(eng_done && state == ST_ERASE), .ers_sect(tgt_sect),
    .rd_addr(addr[MEM_AW-1:0]), .rd_data(rd_word)
  );

  always_comb begin
    tog_d = 1'b0;
    if (busy) tog_d = rd_start ? ~tog : tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= tog_d;
  end

  assign status = {8'h00, (state == ST_PROG) & ~prog_b7, tog, 6'b0};
  assign rd_val = byte_n ? rd_word
                : (dq_in[15] ? {8'h00, rd_word[15:8]} : {8'h00, rd_word[7:0]});
  assign dq_out = busy ? status : rd_val;
  assign dq_oe  = rd_act;
  assign ry_by  = ~busy;

  // R8
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done && rd_start && hw_rst_n) |=> (tog != $past(tog)));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  logic        clk, rst_n, hw_rst_n, ce_n, we_n, oe_n, byte_n;
  logic [11:0] addr;
  logic [15:0] dq_in, dq_out;
  logic        dq_oe, ry_by;
  int          n_chk, n_fail;
  logic [15:0] v;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // op: 0 write, 1 read and compare, 2 wait for ready
  localparam int NV = 20;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 12'h555, 16'h00AA, 16'h0000},
    {2'd0, 12'h2AA, 16'h0055, 16'h0000},
    {2'd0, 12'h555, 16'h00A0, 16'h0000},
    {2'd0, 12'h010, 16'h1234, 16'h0000},
    {2'd1, 12'h010, 16'h0000, 16'h00C0},
    {2'd1, 12'h010, 16'h0000, 16'h0080},
    {2'd2, 12'h000, 16'h0000, 16'h0000},
    {2'd1, 12'h010, 16'h0000, 16'h1234},
    {2'd0, 12'h555, 16'h00AA, 16'h0000},
    {2'd0, 12'h2AB, 16'h0055, 16'h0000},
    {2'd0, 12'h555, 16'h00A0, 16'h0000},
    {2'd0, 12'h011, 16'h0000, 16'h0000},
    {2'd1, 12'h011, 16'h0000, 16'hFFFF},
    {2'd0, 12'h555, 16'h00AA, 16'h0000},
    {2'd0, 12'h2AA, 16'h0055, 16'h0000},
    {2'd0, 12'h555, 16'h00A0, 16'h0000},
    {2'd0, 12'h010, 16'h0F8F, 16'h0000},
    {2'd1, 12'h010, 16'h0000, 16'h0040},
    {2'd2, 12'h000, 16'h0000, 16'h0000},
    {2'd1, 12'h010, 16'h0000, 16'h0204}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic lane, output logic [15:0] val);
    addr = a; dq_in = {lane, 15'b0}; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    val = dq_out;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready(input string tag);
    for (int k = 0; k < 200 && !ry_by; k++) @(negedge clk);
    check(tag, {15'b0, ry_by}, 16'h0001);
  endtask

  task automatic unlock_prog();
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; hw_rst_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    byte_n = 1'b1; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state and read drive enable
    check("R11 ry_by", {15'b0, ry_by}, 16'h0001);
    check("R11 dq_oe idle", {15'b0, dq_oe}, 16'h0000);
    addr = 12'h000; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R11 dq_oe read", {15'b0, dq_oe}, 16'h0001);
    check("R11 erased", dq_out, 16'hFFFF);
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);

    // Table: R1 program, R8 status, R2 bad unlock, R3 AND programming
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][45:44])
        2'd0: wr(VEC[i][43:32], VEC[i][31:16]);
        2'd1: begin
          rd(VEC[i][43:32], 1'b0, v);
          check($sformatf("R1/R2/R3/R8 vec %0d", i), v, VEC[i][15:0]);
        end
        default: wait_ready($sformatf("R1 ready vec %0d", i));
      endcase
    end

    // R1 exact busy length
    unlock_prog(); wr(12'h040, 16'h00FF);
    check("R1 busy start", {15'b0, ry_by}, 16'h0000);
    repeat (7) @(negedge clk);
    check("R1 busy last", {15'b0, ry_by}, 16'h0000);
    @(negedge clk);
    check("R1 ready", {15'b0, ry_by}, 16'h0001);

    // R5 commands ignored while programming
    unlock_prog(); wr(12'h020, 16'h00AA);
    wr(12'h555, 16'h00AA); wr(12'h020, 16'h0000);
    check("R5 still busy", {15'b0, ry_by}, 16'h0000);
    wait_ready("R5 ready");
    rd(12'h020, 1'b0, v); check("R5 data", v, 16'h00AA);

    // R4 address at write start, data at write end
    unlock_prog();
    addr = 12'h024; dq_in = 16'h0000; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = 12'h025; dq_in = 16'h1111;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    wait_ready("R4 ready");
    rd(12'h024, 1'b0, v); check("R4 latched addr", v, 16'h1111);
    rd(12'h025, 1'b0, v); check("R4 other addr", v, 16'hFFFF);

    // R6 / R7 sector erase with suspend
    unlock_prog(); wr(12'h030, 16'h5555);
    wait_ready("R6 prep");
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0080);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h013, 16'h0030);
    check("R6 erase busy", {15'b0, ry_by}, 16'h0000);
    rd(12'h010, 1'b0, v); check("R8 erase status", v, 16'h0040);
    wr(12'h555, 16'h00F0);
    check("R7 ignore F0", {15'b0, ry_by}, 16'h0000);
    wr(12'h000, 16'h00B0);
    check("R7 suspended ready", {15'b0, ry_by}, 16'h0001);
    rd(12'h030, 1'b0, v); check("R7 read other sector", v, 16'h5555);
    repeat (60) @(negedge clk);
    check("R7 frozen", {15'b0, ry_by}, 16'h0001);
    wr(12'h000, 16'h0030);
    check("R7 resumed", {15'b0, ry_by}, 16'h0000);
    wait_ready("R6 ready");
    rd(12'h010, 1'b0, v); check("R6 erased 010", v, 16'hFFFF);
    rd(12'h01F, 1'b0, v); check("R6 erased 01F", v, 16'hFFFF);
    rd(12'h030, 1'b0, v); check("R6 kept 030", v, 16'h5555);
    rd(12'h024, 1'b0, v); check("R6 kept 024", v, 16'h1111);

    // R9 hardware reset aborts a program
    unlock_prog(); wr(12'h021, 16'h0000);
    hw_rst_n = 1'b0;
    @(negedge clk);
    hw_rst_n = 1'b1;
    check("R9 ready", {15'b0, ry_by}, 16'h0001);
    repeat (10) @(negedge clk);
    rd(12'h021, 1'b0, v); check("R9 array untouched", v, 16'hFFFF);

    // R10 byte mode
    byte_n = 1'b0;
    unlock_prog(); wr(12'h022, 16'h803C);
    wait_ready("R10 ready");
    rd(12'h022, 1'b1, v); check("R10 upper byte", v, 16'h003C);
    rd(12'h022, 1'b0, v); check("R10 lower byte", v, 16'h00FF);
    byte_n = 1'b1;
    rd(12'h022, 1'b0, v); check("R10 word view", v, 16'h3CFF);

    report();
  end
endmodule